// File: doc/BRIEF.md
# 4B/5B Transmit Symbol Encoder

This block sits between a nibble-wide transmit interface of a 100 Mb/s Ethernet physical layer and its scrambler. Each clock it samples a frame enable, an error request and a 4-bit data nibble. From these it produces one registered 5-bit code group, with a valid strobe. The scrambler, serializer and line coder downstream take the code groups in the order they are produced.

Between frames the encoder sends the idle code group without a break. When a frame begins, the first two nibbles are replaced by the start delimiter pair, so the frame keeps its length in symbols. Each later nibble is mapped through the 4B/5B table, or replaced by the transmit error symbol when an error is requested. When the frame enable drops, the end delimiter pair closes the frame and idle resumes.

Top module: `sym5_tx_encoder`

## Requirements
- R1: While `rst` is high, every rising edge loads `code_o` = 11111 and `code_vld_o` = 0. At every rising edge with `rst` low, `code_vld_o` is loaded with 1.
- R2: Outside a frame the encoder emits 11111 (idle), whatever the values of `tx_er` and `txd`.
- R3: If `tx_en` is sampled high in the idle state, the next two code groups are 11000 (J) and then 10001 (K), whatever the values of `txd` and `tx_er`. The two nibbles sampled in those cycles are dropped.
- R4: If `tx_en` is high and `tx_er` is low in the data phase, the sampled nibble is emitted as: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R5: If `tx_en` and `tx_er` are both high in the data phase, the code group 00100 (H) is emitted in place of the data.
- R6: If `tx_en` is sampled low in the data phase, the encoder emits 01101 (T) and then 00111 (R), then returns to idle. R always follows T, and `tx_en` is ignored in the R cycle.
- R7: If `tx_en` is sampled high in the first idle cycle after R, a new J/K pair starts at once. The shortest gap between frames is T, R with no idle code group.
- R8: If `tx_en` is already low when K is sampled, K is still sent and is followed by T and R. A one-nibble frame therefore comes out as J, K, T, R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Frame enable |
| tx_er | input | 1 | Transmit error request |
| txd | input | 4 | Data nibble |
| code_o | output | 5 | Registered 5-bit code group |
| code_vld_o | output | 1 | Code group valid |

## Verification
A wrong sequencer state shows at the ports on the next code group.
- A missing K or R appears one cycle after the J or T that should come before it.
- A frame that is never closed keeps sending data codes where T and R are expected.
- A stuck idle state shows as 11111 in place of J.

The output is registered, so every fault is visible one edge after the sample that causes it. Random frames of mixed length, with error requests mixed in, are compared against a bench model on every cycle, so a wrong state is caught in the cycle it first shows.

// File: rtl/sym5_pkg.sv
package sym5_pkg;

    localparam int NIB_W = 4;
    localparam int CG_W  = 5;

    localparam logic [CG_W-1:0] CG_I = 5'b11111;
    localparam logic [CG_W-1:0] CG_J = 5'b11000;
    localparam logic [CG_W-1:0] CG_K = 5'b10001;
    localparam logic [CG_W-1:0] CG_T = 5'b01101;
    localparam logic [CG_W-1:0] CG_R = 5'b00111;
    localparam logic [CG_W-1:0] CG_H = 5'b00100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SSD_K,
        ST_DATA,
        ST_ESD_T,
        ST_ESD_R
    } seq_state_e;

    typedef enum logic [2:0] {
        SEL_I,
        SEL_J,
        SEL_K,
        SEL_D,
        SEL_H,
        SEL_T,
        SEL_R
    } sym_sel_e;

    typedef struct packed {
        logic              en;
        logic              er;
        logic [NIB_W-1:0]  nib;
    } tx_in_t;

    function automatic logic [CG_W-1:0] nib_to_cg(input logic [NIB_W-1:0] n);
        logic [CG_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sym5_nib_map.sv
module sym5_nib_map
    import sym5_pkg::*;
(
    input  logic [NIB_W-1:0] nib_i,
    output logic [CG_W-1:0]  cg_o
);
    always_comb begin
        cg_o = nib_to_cg(nib_i);
    end
endmodule

// File: rtl/sym5_tx_seq.sv
module sym5_tx_seq
    import sym5_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tx_in_t   in_i,
    output sym_sel_e sel_o
);
    seq_state_e st_q, st_d;

    always_comb begin
        st_d  = st_q;
        sel_o = SEL_I;
        case (st_q)
            ST_IDLE: begin
                if (in_i.en) begin
                    sel_o = SEL_J;
                    st_d  = ST_SSD_K;
                end
            end
            ST_SSD_K: begin
                sel_o = SEL_K;
                st_d  = in_i.en ? ST_DATA : ST_ESD_T;
            end
            ST_DATA: begin
                if (!in_i.en) begin
                    sel_o = SEL_T;
                    st_d  = ST_ESD_R;
                end else if (in_i.er) begin
                    sel_o = SEL_H;
                end else begin
                    sel_o = SEL_D;
                end
            end
            ST_ESD_T: begin
                sel_o = SEL_T;
                st_d  = ST_ESD_R;
            end
            ST_ESD_R: begin
                sel_o = SEL_R;
                st_d  = ST_IDLE;
            end
            default: begin
                sel_o = SEL_I;
                st_d  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/sym5_tx_encoder.sv
module sym5_tx_encoder
    import sym5_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    output logic [CG_W-1:0]  code_o,
    output logic             code_vld_o
);
    tx_in_t          in_s;
    sym_sel_e        sel;
    logic [CG_W-1:0] data_cg;
    logic [CG_W-1:0] cg_d;

    assign in_s = '{en: tx_en, er: tx_er, nib: txd};

    sym5_nib_map u_map (
        .nib_i (in_s.nib),
        .cg_o  (data_cg)
    );

    sym5_tx_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .in_i  (in_s),
        .sel_o (sel)
    );

    always_comb begin
        case (sel)
            SEL_J:   cg_d = CG_J;
            SEL_K:   cg_d = CG_K;
            SEL_D:   cg_d = data_cg;
            SEL_H:   cg_d = CG_H;
            SEL_T:   cg_d = CG_T;
            SEL_R:   cg_d = CG_R;
            default: cg_d = CG_I;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o     <= CG_I;
            code_vld_o <= 1'b0;
        end else begin
            code_o     <= cg_d;
            code_vld_o <= 1'b1;
        end
    end
endmodule

// File: rtl/sym5_tx_chk.sv
module sym5_tx_chk
    import sym5_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tx_en,
    input logic             tx_er,
    input logic [CG_W-1:0]  code_o,
    input logic             code_vld_o
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (code_o == CG_I && !code_vld_o)); // R1
    AST_VALID_RUN: assert property (@(posedge clk) disable iff (rst) !rst |=> code_vld_o); // R1
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst) (code_o == CG_I) |=> (code_o == CG_I || code_o == CG_J)); // R2
    AST_J_THEN_K: assert property (@(posedge clk) disable iff (rst) (code_vld_o && code_o == CG_J) |=> (code_o == CG_K)); // R3
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst) (code_o == CG_H && tx_en && tx_er) |=> (code_o == CG_H)); // R5
    AST_T_THEN_R: assert property (@(posedge clk) disable iff (rst) (code_o == CG_T) |=> (code_o == CG_R)); // R6
    AST_R_NEXT: assert property (@(posedge clk) disable iff (rst) (code_o == CG_R) |=> (code_o == CG_I || code_o == CG_J)); // R7
endmodule

bind sym5_tx_encoder sym5_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .tx_er      (tx_er),
    .code_o     (code_o),
    .code_vld_o (code_vld_o)
);

// File: tb/sym5_tx_encoder_tb.sv
`timescale 1ns/1ps
module sym5_tx_encoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic [4:0] code_o;
    logic       code_vld_o;

    int n_chk = 0;
    int n_fail = 0;
    int ms = 0; // 0 idle, 1 K next, 2 data, 3 T next, 4 R next
    bit done = 0;

    always #2.5 clk = ~clk;

    sym5_tx_encoder u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .code_o(code_o), .code_vld_o(code_vld_o)
    );

    function automatic logic [4:0] ref_cg(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: code actual %b expected %b", req, got, exp);
        end
    endtask

    // one clock: drive at negedge, update model, sample after the edge
    task automatic cyc(input logic en, input logic er, input logic [3:0] d, input string tag);
        logic [4:0] e;
        string r;
        @(negedge clk);
        tx_en = en; tx_er = er; txd = d;
        case (ms)
            0: if (en) begin e = 5'b11000; ms = 1; r = "R3"; end
               else begin e = 5'b11111; r = "R2"; end
            1: begin e = 5'b10001; ms = en ? 2 : 3; r = "R3"; end
            2: if (!en) begin e = 5'b01101; ms = 4; r = "R6"; end
               else if (er) begin e = 5'b00100; r = "R5"; end
               else begin e = ref_cg(d); r = "R4"; end
            3: begin e = 5'b01101; ms = 4; r = "R8"; end
            default: begin e = 5'b00111; ms = 0; r = "R6"; end
        endcase
        if (tag != "") r = tag;
        @(posedge clk);
        #1;
        chk(r, code_o, e);
        n_chk++;
        if (code_vld_o !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: valid actual %b expected 1", code_vld_o);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        summary();
    end

    initial begin
        bit en_r;
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", code_o, 5'b11111);
        n_chk++;
        if (code_vld_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: valid actual %b expected 0", code_vld_o);
        end
        @(negedge clk);
        rst = 1'b0;
        // R2 idle with noise on tx_er and txd
        cyc(0, 1, 4'hA, "R2");
        cyc(0, 0, 4'h5, "R2");
        // R3 J/K replaces first two nibbles, tx_er ignored
        cyc(1, 1, 4'h5, "R3");
        cyc(1, 1, 4'h5, "R3");
        // R4 all sixteen nibbles
        for (int i = 0; i < 16; i++) cyc(1, 0, 4'(i), "R4");
        // R5 error symbol
        cyc(1, 1, 4'h3, "R5");
        cyc(1, 0, 4'hF, "R4");
        // R6 end delimiter, tx_en ignored in R cycle
        cyc(0, 0, 4'h0, "R6");
        cyc(1, 0, 4'h0, "R6");
        // R7 back-to-back frame starts right after R
        cyc(1, 0, 4'h0, "R7");
        cyc(1, 0, 4'h0, "R7");
        cyc(1, 0, 4'h9, "R4");
        cyc(0, 0, 4'h0, "R6");
        cyc(0, 0, 4'h0, "R6");
        cyc(0, 0, 4'h0, "R2");
        // R8 one-nibble frame: J K T R
        cyc(1, 0, 4'h0, "R8");
        cyc(0, 0, 4'h0, "R8");
        cyc(0, 0, 4'h0, "R8");
        cyc(0, 0, 4'h0, "R8");
        cyc(0, 0, 4'h0, "R2");
        // random traffic with a fixed seed
        void'($urandom(32'h5A17));
        en_r = 0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) en_r = ~en_r;
            cyc(en_r, $urandom_range(9) == 0, 4'($urandom_range(15)), "");
        end
        summary();
    end
endmodule